// File: doc/BRIEF.md
# Shared Level Interrupt Aggregator

This block folds the level-sensitive interrupt pins of a row of device slots onto four shared interrupt lines. Every slot presents four pins. The block samples all of them on each clock. It keeps the level it last saw for every pin, and it keeps one counter per line of how many pins are asserting that line at present. A line reads high whenever its counter is nonzero. The counters are also brought out for debug.

The routing from pins to lines rotates with the slot number, so pin 0 of neighbouring slots lands on different lines. This spreads the load across the four lines. A counter moves only when a stored pin level actually changes. When several pins change in one cycle, the rising and falling pins that feed each line are summed first, and the counter is then updated once with the net result. The reset is synchronous and clears both the counters and the stored pin levels.

Top module: `intagg_top`

## Requirements
- R1: A pin level present at a rising clock edge shows up in `line_cnt` and `line_out` right after that same edge. The outputs do not change before the edge.
- R2: If a sampled pin level equals the stored level for that pin, no counter changes.
- R3: Each counter equals the number of stored pin levels that are 1 and route to that line. A single pin change moves exactly one counter, by +1 or -1.
- R4: `line_out[l]` is 1 exactly when counter `l` is nonzero.
- R5: When `rst` is high at a clock edge, every counter and every stored pin level becomes 0, whatever the pins show.
- R6: Pin `p` of slot `s` is bit `s*4+p` of `pin_lvl` and drives line `(p+s) mod 4`. Counter `l` occupies bits `[l*CW +: CW]` of `line_cnt`, where CW = clog2(NUM_SLOTS*4+1), which is 8 by default.
- R7: Rises and falls on any number of slots in the same cycle are all applied, netted per line, in one update.
- R8: A counter can hold the case where every pin asserts at once (32 per line by default). No counter ever underflows or overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_lvl | input | NUM_SLOTS*4 | Pin levels, bit s*4+p is pin p of slot s |
| line_out | output | 4 | Shared line levels |
| line_cnt | output | 4*CW | Per-line counters of asserting pins |

## Verification
A pin change is registered at the next clock edge, so both the counters and the line levels are due exactly one edge after the stimulus. The bench drives inputs on the falling edge. It first samples just before the rising edge to confirm the old values still hold. It then checks the new values on the following falling edge, against counters it rebuilds from its own copy of the stored pin levels. Stimulus that repeats the same levels, and reset applied while pins are high, are checked one edge later in the same way.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  localparam int PINS_PER_SLOT = 4;
  localparam int NUM_LINES     = 4;

  // rotation of a slot's pins onto the shared lines
  function automatic logic [1:0] route_line(input int slot, input int pin);
    return 2'((slot + pin) % NUM_LINES);
  endfunction
endpackage

// File: rtl/intagg_pin_state.sv
module intagg_pin_state #(
  parameter int NUM_SLOTS = 32,
  localparam int NPINS = NUM_SLOTS * intagg_pkg::PINS_PER_SLOT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_lvl,
  output logic [NPINS-1:0] stored,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] fall,
  output logic             chg_any
);
  always_ff @(posedge clk) begin
    if (rst) stored <= '0;
    else     stored <= pin_lvl;
  end

  always_comb begin
    rise    = pin_lvl & ~stored;
    fall    = ~pin_lvl & stored;
    chg_any = |(rise | fall);
  end

  // R5: reset leaves no stored level behind
  a_r5_state_clear: assert property (@(posedge clk) rst |=> stored == '0);
endmodule

// File: rtl/intagg_line_sum.sv
module intagg_line_sum #(
  parameter int NUM_SLOTS = 32,
  parameter int CW = 8,
  localparam int NPINS = NUM_SLOTS * intagg_pkg::PINS_PER_SLOT
) (
  input  logic [NPINS-1:0] rise,
  input  logic [NPINS-1:0] fall,
  output logic [intagg_pkg::NUM_LINES-1:0][CW-1:0] up,
  output logic [intagg_pkg::NUM_LINES-1:0][CW-1:0] dn
);
  import intagg_pkg::*;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    always_comb begin
      up[l] = '0;
      dn[l] = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        for (int p = 0; p < PINS_PER_SLOT; p++) begin
          if (route_line(s, p) == 2'(l)) begin
            up[l] = up[l] + CW'(rise[s*PINS_PER_SLOT+p]);
            dn[l] = dn[l] + CW'(fall[s*PINS_PER_SLOT+p]);
          end
        end
      end
    end
  end
endmodule

// File: rtl/intagg_line_cnt.sv
module intagg_line_cnt #(
  parameter int CW = 8,
  parameter int MAXV = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] up,
  input  logic [CW-1:0] dn,
  output logic [CW-1:0] cnt,
  output logic          asserted
);
  function automatic logic [CW:0] apply_delta(input logic [CW-1:0] c,
                                               input logic [CW-1:0] u,
                                               input logic [CW-1:0] d);
    return {1'b0, c} + {1'b0, u} - {1'b0, d};
  endfunction

  logic [CW:0] nxt;
  always_comb nxt = apply_delta(cnt, up, dn);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt[CW-1:0];
  end

  assign asserted = (cnt != '0);

  // R8: never drops below zero
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt} + {1'b0, up}) >= {1'b0, dn});
  // R8: never exceeds the number of pins that route here
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    nxt <= (CW+1)'(MAXV));
  // R5: counter cleared by reset
  a_r5_cnt_clear: assert property (@(posedge clk) rst |=> cnt == '0);
  // R4: line follows counter on the next edge after an update
  a_r4_line: assert property (@(posedge clk) disable iff (rst)
    (nxt != '0) |=> asserted);
endmodule

// File: rtl/intagg_top.sv
module intagg_top #(
  parameter int NUM_SLOTS = 32,
  localparam int NPINS = NUM_SLOTS * intagg_pkg::PINS_PER_SLOT,
  localparam int CW = $clog2(NPINS + 1),
  localparam int NL = intagg_pkg::NUM_LINES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_lvl,
  output logic [NL-1:0]     line_out,
  output logic [NL*CW-1:0]  line_cnt
);
  logic [NPINS-1:0] stored, rise, fall;
  logic chg_any;
  logic [NL-1:0][CW-1:0] up, dn, cnt;

  intagg_pin_state #(.NUM_SLOTS(NUM_SLOTS)) u_state (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl),
    .stored(stored), .rise(rise), .fall(fall), .chg_any(chg_any));

  intagg_line_sum #(.NUM_SLOTS(NUM_SLOTS), .CW(CW)) u_sum (
    .rise(rise), .fall(fall), .up(up), .dn(dn));

  for (genvar l = 0; l < NL; l++) begin : g_cnt
    intagg_line_cnt #(.CW(CW), .MAXV(NPINS / NL)) u_cnt (
      .clk(clk), .rst(rst), .up(up[l]), .dn(dn[l]),
      .cnt(cnt[l]), .asserted(line_out[l]));
    assign line_cnt[l*CW +: CW] = cnt[l];
  end

  // total of all counters, kept for the checks below
  logic [CW+1:0] cnt_total;
  always_comb begin
    cnt_total = '0;
    for (int l = 0; l < NL; l++) cnt_total = cnt_total + (CW+2)'(cnt[l]);
  end

  // R2: no pin change means no counter moves
  a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
    !chg_any |=> $stable(cnt));
  // R3: counters account for exactly the stored asserted pins
  a_r3_total: assert property (@(posedge clk) disable iff (rst)
    cnt_total == (CW+2)'($countones(stored)));
endmodule

// File: tb/intagg_top_test.sv
module intagg_top_test;
  localparam int NS = 32;
  localparam int NP = NS * 4;
  localparam int CW = $clog2(NP + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] pin_lvl = '0;
  logic [3:0] line_out;
  logic [4*CW-1:0] line_cnt;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [NP-1:0] mstore = '0;

  always #5 clk = ~clk;

  intagg_top #(.NUM_SLOTS(NS)) uut (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl),
    .line_out(line_out), .line_cnt(line_cnt));

  function automatic int exp_cnt(input logic [NP-1:0] st, input int line);
    int n = 0;
    for (int i = 0; i < NP; i++) begin
      // slot i/4, pin i%4; line advances one per slot
      if (st[i] && (((i / 4) & 3) ^ 0) == ((line - (i % 4) + 4) & 3)) n++;
    end
    return n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int l = 0; l < 4; l++) begin
      int e;
      e = exp_cnt(mstore, l);
      chk(req, int'(line_cnt[l*CW +: CW]), e);
      chk({req, " R4"}, int'(line_out[l]), int'(e != 0));
    end
  endtask

  task automatic apply(input logic [NP-1:0] pins, input logic r, input string req);
    @(negedge clk);
    pin_lvl = pins;
    rst = r;
    @(negedge clk);
    mstore = r ? '0 : pins;
    check_all(req);
  endtask

  task automatic t_reset_state();
    check_all("R5 reset state");
  endtask

  task automatic t_single();
    logic [3:0] before_l;
    @(negedge clk);
    before_l = line_out;
    pin_lvl = '0;
    pin_lvl[0] = 1'b1;       // slot 0 pin 0 -> line 0
    #3;
    chk("R1 no early change", int'(line_out), int'(before_l));
    @(negedge clk);
    mstore = pin_lvl;
    check_all("R1 R3 single pin");
    chk("R6 slot0 pin0 line0", int'(line_cnt[0 +: CW]), 1);
  endtask

  task automatic t_rotation();
    logic [NP-1:0] p = '0;
    p[1*4+0] = 1'b1;  // slot 1 pin 0 -> line 1
    p[3*4+2] = 1'b1;  // slot 3 pin 2 -> line 1
    p[2*4+3] = 1'b1;  // slot 2 pin 3 -> line 1
    apply(p, 1'b0, "R6 rotation");
    chk("R6 line1 holds three", int'(line_cnt[1*CW +: CW]), 3);
    chk("R6 line0 empty", int'(line_cnt[0 +: CW]), 0);
  endtask

  task automatic t_repeat();
    logic [NP-1:0] p = pin_lvl;
    apply(p, 1'b0, "R2 repeat 1");
    apply(p, 1'b0, "R2 repeat 2");
    chk("R2 line1 unchanged", int'(line_cnt[1*CW +: CW]), 3);
  endtask

  task automatic t_simul();
    logic [NP-1:0] p = pin_lvl;
    p[1*4+0] = 1'b0;                   // fall on line 1
    p[5*4+0] = 1'b1;                   // rise on line 1
    p[7*4+1] = 1'b1;                   // rise on line 0
    p[20*4+3] = 1'b1;                  // rise on line 3
    p[31*4+2] = 1'b1;                  // rise on line 1
    apply(p, 1'b0, "R7 simultaneous");
    chk("R7 line1 net", int'(line_cnt[1*CW +: CW]), 4);
  endtask

  task automatic t_full();
    apply('1, 1'b0, "R8 all asserted");
    for (int l = 0; l < 4; l++) chk("R8 full line", int'(line_cnt[l*CW +: CW]), NS);
    apply('0, 1'b0, "R3 R4 all released");
  endtask

  task automatic t_reset_mid();
    logic [NP-1:0] p = '0;
    p[9*4+1] = 1'b1;
    p[12*4+0] = 1'b1;
    apply(p, 1'b0, "R3 before reset");
    apply(p, 1'b1, "R5 reset with pins high");
    apply(p, 1'b0, "R5 recount after reset");
    chk("R5 line2 recounted", int'(line_cnt[2*CW +: CW]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_single();
    t_rotation();
    t_repeat();
    t_simul();
    t_full();
    t_reset_mid();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule